// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer driven by a slow timer tick and programmed over a simple single-cycle register bus. An up-counter advances on every timer tick, or on every 2^N-th tick when the prescaler is on. Software keeps the system alive by writing a trigger register, which reloads the counter from a load register. If the counter rolls over from all ones while the timer runs, the block raises a one-cycle reset request and reloads itself.

The timer runs and stops only in response to two-word key sequences written to a key register. A single stray write therefore cannot stop it. Writes to the four timer-side registers are posted: the bus write sets a pending flag, and the new value reaches the timer two ticks later. A status register shows which of these writes are still in flight, and software polls it before it writes the same register again. The slow timer clock appears here as a one-cycle `tick` strobe in the bus clock domain.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the timer is stopped, the reset output is low, and the control, load, trigger, counter and pending-status registers all read 0.
- R2: Word address map: 0 control, 1 load, 2 trigger, 3 key, 4 pending status, 5 counter, 6 system configuration. A write to control, load, trigger or key sets its pending bit (status bit 0, 2, 3 or 4 respectively) from the next cycle. The bit clears, and the value takes effect, on the second tick after the write; until then a read of the register returns its old value.
- R3: A bus write to a posted register whose pending bit is set is discarded.
- R4: Once the key register has taken 0xBBBB and then 0x4444, the timer runs.
- R5: Once the key register has taken 0xAAAA and then 0x5555, the timer stops.
- R6: After a first key word, any other word than its matching second word cancels the sequence and the run state does not change; a second key word that arrives without its first word has no effect.
- R7: A trigger value that takes effect reloads the counter from the load register only when it differs from the previously applied trigger value (0 after reset).
- R8: Control bit 5 enables the prescaler and control bits 4:2 hold P. With the prescaler off, the running counter adds one per tick; with it on, it adds one per 2^P ticks.
- R9: On a counting step from all ones while the timer runs, the reset output is high for exactly one cycle and the counter reloads from the load register.
- R10: While the timer is stopped the counter holds its value except on a trigger reload.
- R11: System configuration bit 0 is written directly (not posted) and reads back; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe for each slow timer clock edge |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Word address of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| wdtRst | output | 1 | One-cycle reset request on counter rollover |

## Verification
Assertions check on every cycle that the counter only steps by one, reloads, or holds while stopped. They also check that the reset request only follows a running timer and leaves the counter at the load value, and that the run state and pending flags only change on a tick or after a matching write. Only the bench scenarios can show the actual key decoding, with its correct, broken and orphaned sequences. The same holds for the exact tick on which a posted value lands, the trigger-must-differ rule, the prescaler divide ratio and the rollover period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W = 3;

  typedef struct packed {
    logic             timerOn;
    logic             prescEn;
    logic [PRE_W-1:0] prescVal;
    logic             reloadStb;
  } wdogStrobe_t;

  typedef enum logic [1:0] {
    KEY_IDLE,
    KEY_GOT_ON,
    KEY_GOT_OFF
  } keyState_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 3,
  parameter int POST_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countVal,
  output wdogStrobe_t       ctl,
  output logic [CNT_W-1:0]  loadVal
);
  localparam int NSLOT = 4;
  localparam int AGE_W = $clog2(POST_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(6);
  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  // slot order: 0 control, 1 load, 2 trigger, 3 key
  function automatic logic [ADDR_W-1:0] slotAddr(input int s);
    return ADDR_W'(s);
  endfunction

  logic [NSLOT-1:0]  pendV;
  logic [NSLOT-1:0]  applyStb;
  logic [DATA_W-1:0] shadowV [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic              slotPend;
    logic [AGE_W-1:0]  slotAge;
    logic [DATA_W-1:0] slotVal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotPend <= 1'b0;
        slotAge  <= '0;
        slotVal  <= '0;
      end else if (busWe && busAddr == slotAddr(s) && !slotPend) begin
        slotPend <= 1'b1;
        slotAge  <= AGE_W'(POST_TICKS);
        slotVal  <= busWdata;
      end else if (slotPend && tick) begin
        if (slotAge == AGE_W'(1)) slotPend <= 1'b0;
        slotAge <= slotAge - AGE_W'(1);
      end
    end

    assign pendV[s]    = slotPend;
    assign shadowV[s]  = slotVal;
    assign applyStb[s] = slotPend && tick && slotAge == AGE_W'(1);
  end

  logic [PRE_W:0]    ctrlReg;
  logic [CNT_W-1:0]  loadReg;
  logic [DATA_W-1:0] lastTrig;
  logic              timerOn;
  logic              sysCfg;
  keyState_t         keyState;
  logic [15:0]       keyWord;

  assign keyWord = shadowV[3][15:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      loadReg  <= '0;
      lastTrig <= '0;
      timerOn  <= 1'b0;
      sysCfg   <= 1'b0;
      keyState <= KEY_IDLE;
    end else begin
      if (applyStb[0]) ctrlReg <= shadowV[0][PRE_W+2:2];
      if (applyStb[1]) loadReg <= shadowV[1][CNT_W-1:0];
      if (applyStb[2]) lastTrig <= shadowV[2];
      if (busWe && busAddr == A_SYS) sysCfg <= busWdata[0];
      if (applyStb[3]) begin
        unique case (keyState)
          KEY_GOT_ON: begin
            if (keyWord == KEY_ON2) timerOn <= 1'b1;
            keyState <= KEY_IDLE;
          end
          KEY_GOT_OFF: begin
            if (keyWord == KEY_OFF2) timerOn <= 1'b0;
            keyState <= KEY_IDLE;
          end
          default: begin
            if (keyWord == KEY_ON1)       keyState <= KEY_GOT_ON;
            else if (keyWord == KEY_OFF1) keyState <= KEY_GOT_OFF;
            else                          keyState <= KEY_IDLE;
          end
        endcase
      end
    end
  end

  logic [4:0] pendBits;
  assign pendBits = {pendV[3], pendV[2], pendV[1], 1'b0, pendV[0]};

  always_comb begin
    ctl.timerOn   = timerOn;
    ctl.prescEn   = ctrlReg[PRE_W];
    ctl.prescVal  = ctrlReg[PRE_W-1:0];
    ctl.reloadStb = applyStb[2] && (shadowV[2] != lastTrig);
  end
  assign loadVal = loadReg;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTRL: busRdata = DATA_W'({ctrlReg, 2'b00});
      A_LOAD: busRdata = DATA_W'(loadReg);
      A_TRIG: busRdata = lastTrig;
      A_PEND: busRdata = DATA_W'(pendBits);
      A_CNT:  busRdata = DATA_W'(countVal);
      A_SYS:  busRdata = DATA_W'(sysCfg);
      default: busRdata = '0;
    endcase
  end

  assert_run_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(timerOn) |-> $past(tick));
  assert_key_pend_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendBits[4]) |-> $past(busWe && busAddr == A_KEY));
  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendBits[2]) |-> $past(tick));
  assert_load_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(pendV[1]) && pendV[1] |-> $stable(shadowV[1]));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  wdogStrobe_t      ctl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countVal,
  output logic             wdtRst
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divLimit;
  logic             cntTick;

  assign divLimit = (DIV_W'(1) << ctl.prescVal) - DIV_W'(1);
  assign cntTick  = tick && (!ctl.prescEn || preCnt == divLimit);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.prescEn) preCnt <= '0;
    else if (tick) preCnt <= (preCnt == divLimit) ? '0 : preCnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      wdtRst   <= 1'b0;
    end else begin
      wdtRst <= 1'b0;
      if (ctl.reloadStb) begin
        countVal <= loadVal;
      end else if (ctl.timerOn && cntTick) begin
        if (&countVal) begin
          countVal <= loadVal;
          wdtRst   <= 1'b1;
        end else begin
          countVal <= countVal + CNT_W'(1);
        end
      end
    end
  end

  assert_rst_when_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> $past(ctl.timerOn));
  assert_rst_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> countVal == $past(loadVal));
  assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.timerOn && !ctl.reloadStb |=> $stable(countVal));
  assert_step_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(countVal) && !$past(ctl.reloadStb) && !wdtRst
      |-> countVal == $past(countVal) + CNT_W'(1));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 3,
  parameter int POST_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              wdtRst
);
  wdogStrobe_t      ctl;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] countVal;

  wdog_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .POST_TICKS(POST_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .countVal(countVal),
    .ctl(ctl), .loadVal(loadVal)
  );

  wdog_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .loadVal(loadVal),
    .countVal(countVal), .wdtRst(wdtRst)
  );
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wdtRst;

  always #10 clk = ~clk;

  wdog_keyed u_wdog_keyed (
    .clk(clk), .rstN(rstN), .tick(tick), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wdtRst(wdtRst)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  logic  rdReq = 1'b0;
  int    checks = 0, errors = 0;
  int    rstCount = 0, runLen = 0, maxRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (wdtRst) begin
        runLen++;
        if (runLen == 1) rstCount++;
        if (runLen > maxRun) maxRun = runLen;
      end else runLen = 0;
    end
    if (rdReq) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (busRdata !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic readExp(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    busAddr = a;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    rdReq = 1'b1;
    @(posedge clk); #1;
    rdReq = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic postW(input logic [2:0] a, input logic [31:0] d);
    busWrite(a, d);
    tickN(2);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readExp(3'd0, 32'h0, "R1 control");
    readExp(3'd1, 32'h0, "R1 load");
    readExp(3'd4, 32'h0, "R1 pending");
    readExp(3'd5, 32'h0, "R1 counter");

    // R2 posting of load, R3 dropped write while pending
    busWrite(3'd1, 32'h100);
    readExp(3'd4, 32'h04, "R2 load pending");
    readExp(3'd1, 32'h0, "R2 load old value");
    busWrite(3'd1, 32'h999);
    tickN(1);
    readExp(3'd4, 32'h04, "R2 pending after one tick");
    tickN(1);
    readExp(3'd4, 32'h0, "R2 pending cleared");
    readExp(3'd1, 32'h100, "R3 second write dropped");

    // R7 trigger reload only on changed value
    postW(3'd2, 32'h0);
    readExp(3'd5, 32'h0, "R7 same trigger no reload");
    postW(3'd2, 32'h1234);
    readExp(3'd5, 32'h100, "R7 new trigger reloads");

    // R10 stopped counter holds
    tickN(5);
    readExp(3'd5, 32'h100, "R10 hold while stopped");

    // R6 broken and orphaned sequences
    postW(3'd3, 32'hBBBB);
    postW(3'd3, 32'h1234);
    tickN(3);
    readExp(3'd5, 32'h100, "R6 broken start sequence");
    postW(3'd3, 32'h4444);
    tickN(3);
    readExp(3'd5, 32'h100, "R6 orphan second key");

    // R4 start, R8 counting without prescaler
    postW(3'd3, 32'hBBBB);
    postW(3'd3, 32'h4444);
    readExp(3'd5, 32'h100, "R4 start lands");
    tickN(3);
    readExp(3'd5, 32'h103, "R8 one per tick");

    // R8 prescaler 2^2
    postW(3'd0, 32'h28);
    readExp(3'd0, 32'h28, "R2 control applied");
    readExp(3'd5, 32'h105, "R8 before prescale");
    tickN(8);
    readExp(3'd5, 32'h107, "R8 prescale by four");
    tickN(3);
    readExp(3'd5, 32'h107, "R8 prescale partial");
    tickN(1);
    readExp(3'd5, 32'h108, "R8 prescale step");
    postW(3'd0, 32'h0);
    readExp(3'd5, 32'h108, "R8 prescale off");

    // R9 rollover
    postW(3'd1, 32'hFFFF_FFFD);
    postW(3'd2, 32'hEDCB);
    readExp(3'd5, 32'hFFFF_FFFD, "R7 reload to near top");
    tickN(2);
    @(negedge clk); #1;
    checkVal("R9 no reset before rollover", rstCount, 0);
    tickN(1);
    @(negedge clk); #1;
    checkVal("R9 reset pulse", rstCount, 1);
    readExp(3'd5, 32'hFFFF_FFFD, "R9 reload after rollover");

    // R5 stop
    postW(3'd3, 32'hAAAA);
    postW(3'd3, 32'h5555);
    tickN(4);
    @(negedge clk); #1;
    checkVal("R5 reset count while stopping", rstCount, 2);
    readExp(3'd5, 32'hFFFF_FFFE, "R5 stopped holds");
    checkVal("R9 pulse width", maxRun, 1);

    // R11 system configuration
    busWrite(3'd6, 32'hFF);
    readExp(3'd6, 32'h1, "R11 config readback");
    busWrite(3'd6, 32'h0);
    readExp(3'd6, 32'h0, "R11 config cleared");

    finishRun();
  end
endmodule